// File: doc/BRIEF.md
# Mode-Configurable Inverting Bus Transceiver

This block is a bidirectional transceiver core, `WIDTH` bits wide, that sits between a three-state logic-level side (side A) and an open-collector wired-OR backplane side (side B). Each direction passes its data through a storage element. A two-bit mode code chooses that element for each direction: a transparent latch, an edge-triggered register, or a plain pass-through path. Every path inverts its data on the way from input to output.

Each direction has its own strobe input. In register mode the strobe is a rising-edge clock. In latch mode the same strobe is a latch enable that is transparent while low. Side A is modelled as a separate input, output value and drive qualifier. Side B is modelled as the resolved line level plus per-bit pull-low and released indications, so the model needs no electrical pins. Side B drives only when its two enables are in the one active combination and the supply is reported good.

Top module: `inv_bus_xcvr`

## Requirements
- R1: With mode code {mode_sel[1],mode_sel[0]} = 2'b00, both directions are latches. Each is transparent while its own strobe (stb_ab or stb_ba) is low and holds while that strobe is high.
- R2: With mode code 2'b10, both directions are pass-through, so outputs follow inputs combinationally, inverted.
- R3: With mode code 2'b01, both directions are registers. The A-to-B register captures a_in on the rising edge of stb_ab, and the B-to-A register captures b_in on the rising edge of stb_ba.
- R4: With mode code 2'b11, A-to-B is a register on the rising edge of stb_ab and B-to-A is a latch that is transparent while stb_ba is low.
- R5: Data is inverted in every mode. A B bit is pulled low (b_pull_low=1, b_released=0) when the inverted A-to-B value is 0, that is, when the stored or passed a_in bit is 1. The a_out value is the bitwise inverse of the stored or passed b_in level.
- R6: a_drive equals oe_a. Side A drives a_out only while oe_a is 1 and is high-impedance otherwise.
- R7: Side B is active only when b_en_hi=1 and b_en_lo=0. In every other combination b_pull_low is all 0 and b_released is all 1.
- R8: Latches and registers keep capturing new data, or keep holding it, while their outputs are disabled. Enabling the outputs then shows the stored data.
- R9: While pwr_good is 0, b_en_hi is treated as 0, so side B is released whatever the enables are.
- R10: While rst_n is 0, all storage is cleared. With side B enabled, this gives b_pull_low all 0, b_released all 1 and a_out all 1 in every stored mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of all storage |
| mode_sel | input | 2 | Storage mode code |
| stb_ab | input | 1 | A-to-B clock or latch enable (latch transparent when low) |
| stb_ba | input | 1 | B-to-A clock or latch enable (latch transparent when low) |
| oe_a | input | 1 | Side A output enable, active high |
| b_en_hi | input | 1 | Side B enable that must be high |
| b_en_lo | input | 1 | Side B enable that must be low |
| pwr_good | input | 1 | Supply good; low forces side B released |
| a_in | input | WIDTH | Side A input level |
| a_out | output | WIDTH | Side A output value |
| a_drive | output | 1 | Side A output driven (low means high-impedance) |
| b_in | input | WIDTH | Resolved wired-OR side B line level |
| b_pull_low | output | WIDTH | Per bit: side B driver sinks the line |
| b_released | output | WIDTH | Per bit: side B driver is off, so the line floats high |

## Verification
The bench builds the block with the default width of nine. An odd width puts the top bit outside any byte-aligned pattern, so the patterns 9'h155, 9'h0AA and 9'h1F0 show whether the ninth bit is inverted, stored and gated like the rest. With this width, every mode code, all four enable combinations, the power gate and the reset value can each be checked against exact expected words.

// File: rtl/inv_bus_xcvr.sv
module inv_bus_xcvr #(
  parameter int WIDTH = 9
) (
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic             stb_ab,
  input  logic             stb_ba,
  input  logic             oe_a,
  input  logic             b_en_hi,
  input  logic             b_en_lo,
  input  logic             pwr_good,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_drive,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_pull_low,
  output logic [WIDTH-1:0] b_released
);

  localparam logic [1:0] CODE_LATCH = 2'b00;
  localparam logic [1:0] CODE_REG   = 2'b01;
  localparam logic [1:0] CODE_PASS  = 2'b10;
  localparam logic [1:0] CODE_SPLIT = 2'b11;

  typedef enum logic [1:0] {ST_LATCH, ST_REG, ST_PASS} store_t;

  store_t ab_kind, ba_kind;
  logic [WIDTH-1:0] ab_reg, ab_lat, ba_reg, ba_lat;
  logic [WIDTH-1:0] ab_val, ba_val;
  logic             b_active;

  always_comb begin
    unique case (mode_sel)
      CODE_LATCH: begin ab_kind = ST_LATCH; ba_kind = ST_LATCH; end
      CODE_REG:   begin ab_kind = ST_REG;   ba_kind = ST_REG;   end
      CODE_PASS:  begin ab_kind = ST_PASS;  ba_kind = ST_PASS;  end
      CODE_SPLIT: begin ab_kind = ST_REG;   ba_kind = ST_LATCH; end
      default:    begin ab_kind = ST_LATCH; ba_kind = ST_LATCH; end
    endcase
  end

  always_ff @(posedge stb_ab or negedge rst_n)
    if (!rst_n) ab_reg <= '0;
    else        ab_reg <= a_in;

  always_ff @(posedge stb_ba or negedge rst_n)
    if (!rst_n) ba_reg <= '0;
    else        ba_reg <= b_in;

  always_latch
    if (!rst_n)      ab_lat = '0;
    else if (!stb_ab) ab_lat = a_in;

  always_latch
    if (!rst_n)      ba_lat = '0;
    else if (!stb_ba) ba_lat = b_in;

  always_comb begin
    unique case (ab_kind)
      ST_REG:  ab_val = ab_reg;
      ST_PASS: ab_val = a_in;
      default: ab_val = ab_lat;
    endcase
    unique case (ba_kind)
      ST_REG:  ba_val = ba_reg;
      ST_PASS: ba_val = b_in;
      default: ba_val = ba_lat;
    endcase
  end

  assign b_active   = b_en_hi & pwr_good & ~b_en_lo;
  assign b_pull_low = ab_val & {WIDTH{b_active}};
  assign b_released = ~b_pull_low;
  assign a_out      = ~ba_val;
  assign a_drive    = oe_a;

endmodule

// File: rtl/inv_bus_xcvr_chk.sv
module inv_bus_xcvr_chk #(
  parameter int WIDTH = 9
) (
  input logic             rst_n,
  input logic [1:0]       mode_sel,
  input logic             stb_ab,
  input logic             stb_ba,
  input logic             b_en_hi,
  input logic             b_en_lo,
  input logic             pwr_good,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] a_out,
  input logic [WIDTH-1:0] b_in,
  input logic [WIDTH-1:0] b_pull_low,
  input logic [WIDTH-1:0] b_released
);

  logic seen_ab;
  logic on_b;
  logic ab_is_reg;

  assign on_b      = b_en_hi & ~b_en_lo & pwr_good;
  assign ab_is_reg = (mode_sel == 2'b01) || (mode_sel == 2'b11);

  always_ff @(posedge stb_ab or negedge rst_n)
    if (!rst_n) seen_ab <= 1'b0;
    else        seen_ab <= 1'b1;

  AST_AB_REG_CAPTURE: assert property (@(posedge stb_ab) disable iff (!rst_n)
    (seen_ab && ab_is_reg && $past(ab_is_reg) && on_b) |-> (b_pull_low == $past(a_in))); // R3

  AST_B_RELEASED_OFF: assert property (@(posedge stb_ab) disable iff (!rst_n)
    !(b_en_hi && !b_en_lo && pwr_good) |-> (b_pull_low == '0 && b_released == '1)); // R7

  AST_B_POWER_GATE: assert property (@(posedge stb_ba) disable iff (!rst_n)
    !pwr_good |-> (b_pull_low == '0)); // R9

  AST_BA_PASS_INVERT: assert property (@(posedge stb_ab) disable iff (!rst_n)
    (mode_sel == 2'b10) |-> (a_out == ~b_in)); // R2

  AST_AB_PASS_DRIVE: assert property (@(posedge stb_ba) disable iff (!rst_n)
    (mode_sel == 2'b10 && on_b) |-> (b_pull_low == a_in)); // R5

endmodule

bind inv_bus_xcvr inv_bus_xcvr_chk #(.WIDTH(WIDTH)) u_chk (
  .rst_n(rst_n), .mode_sel(mode_sel), .stb_ab(stb_ab), .stb_ba(stb_ba),
  .b_en_hi(b_en_hi), .b_en_lo(b_en_lo), .pwr_good(pwr_good),
  .a_in(a_in), .a_out(a_out), .b_in(b_in),
  .b_pull_low(b_pull_low), .b_released(b_released)
);

// File: tb/test_inv_bus_xcvr.sv
module test_inv_bus_xcvr;
  localparam int W = 9;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst_n, stb_ab, stb_ba, oe_a, b_en_hi, b_en_lo, pwr_good;
  logic [1:0]   mode_sel;
  logic [W-1:0] a_in, b_in, a_out, b_pull_low, b_released;
  logic         a_drive;

  int total = 0;
  int bad = 0;

  inv_bus_xcvr #(.WIDTH(W)) i_inv_bus_xcvr (
    .rst_n(rst_n), .mode_sel(mode_sel), .stb_ab(stb_ab), .stb_ba(stb_ba),
    .oe_a(oe_a), .b_en_hi(b_en_hi), .b_en_lo(b_en_lo), .pwr_good(pwr_good),
    .a_in(a_in), .a_out(a_out), .a_drive(a_drive), .b_in(b_in),
    .b_pull_low(b_pull_low), .b_released(b_released)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulse_ab();
    step(); stb_ab = 1'b1; step(); stb_ab = 1'b0; step();
  endtask

  task automatic pulse_ba();
    step(); stb_ba = 1'b1; step(); stb_ba = 1'b0; step();
  endtask

  task automatic b_on();
    b_en_hi = 1'b1; b_en_lo = 1'b0; pwr_good = 1'b1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; b_on(); stb_ab = 1'b0; stb_ba = 1'b0;
    a_in = 9'h1FF; b_in = 9'h1FF;
    mode_sel = 2'b01; step();
    check("R10 reg pull", b_pull_low, '0);
    check("R10 reg rel", b_released, '1);
    check("R10 reg aout", a_out, '1);
    mode_sel = 2'b00; step();
    check("R10 latch pull", b_pull_low, '0);
    check("R10 latch aout", a_out, '1);
    rst_n = 1'b1; step();
  endtask

  task automatic t_pass();
    mode_sel = 2'b10; b_on(); oe_a = 1'b1;
    a_in = 9'h155; b_in = 9'h0F3; step();
    check("R2 pass pull", b_pull_low, 9'h155);
    check("R5 pass rel", b_released, 9'h0AA);
    check("R2 pass aout", a_out, 9'h10C);
    a_in = 9'h1F0; b_in = 9'h100; step();
    check("R2 pass pull2", b_pull_low, 9'h1F0);
    check("R5 pass aout2", a_out, 9'h0FF);
  endtask

  task automatic t_reg();
    mode_sel = 2'b01; b_on();
    a_in = 9'h0AA; b_in = 9'h133; pulse_ab(); pulse_ba();
    check("R3 reg pull", b_pull_low, 9'h0AA);
    check("R3 reg aout", a_out, 9'h0CC);
    a_in = 9'h155; b_in = 9'h000; step();
    check("R3 reg hold pull", b_pull_low, 9'h0AA);
    check("R3 reg hold aout", a_out, 9'h0CC);
    pulse_ab();
    check("R3 reg ab new", b_pull_low, 9'h155);
    check("R3 reg ba own strobe", a_out, 9'h0CC);
    pulse_ba();
    check("R3 reg ba new", a_out, 9'h1FF);
  endtask

  task automatic t_latch();
    mode_sel = 2'b00; b_on(); stb_ab = 1'b0; stb_ba = 1'b0;
    a_in = 9'h10F; b_in = 9'h0F0; step();
    check("R1 latch open pull", b_pull_low, 9'h10F);
    check("R1 latch open aout", a_out, 9'h10F);
    stb_ab = 1'b1; stb_ba = 1'b1; step();
    a_in = 9'h001; b_in = 9'h1FE; step();
    check("R1 latch hold pull", b_pull_low, 9'h10F);
    check("R1 latch hold aout", a_out, 9'h10F);
    stb_ab = 1'b0; stb_ba = 1'b0; step();
    check("R1 latch reopen pull", b_pull_low, 9'h001);
    check("R1 latch reopen aout", a_out, 9'h001);
  endtask

  task automatic t_split();
    mode_sel = 2'b11; b_on(); stb_ab = 1'b0; stb_ba = 1'b0;
    a_in = 9'h0C3; pulse_ab();
    a_in = 9'h03C; b_in = 9'h055; step();
    check("R4 split ab reg holds", b_pull_low, 9'h0C3);
    check("R4 split ba latch open", a_out, 9'h1AA);
    stb_ba = 1'b1; step(); b_in = 9'h1FF; step();
    check("R4 split ba latch hold", a_out, 9'h1AA);
    stb_ba = 1'b0; step();
    check("R4 split ba latch follow", a_out, 9'h000);
  endtask

  task automatic t_enables();
    mode_sel = 2'b10; a_in = 9'h1FF; pwr_good = 1'b1;
    for (int k = 0; k < 4; k++) begin
      b_en_hi = k[1]; b_en_lo = k[0]; step();
      check("R7 enable pull", b_pull_low, (k == 2) ? 9'h1FF : 9'h000);
      check("R7 enable rel", b_released, (k == 2) ? 9'h000 : 9'h1FF);
    end
    oe_a = 1'b0; step();
    check("R6 a off", {8'h0, a_drive}, 9'h000);
    oe_a = 1'b1; step();
    check("R6 a on", {8'h0, a_drive}, 9'h001);
  endtask

  task automatic t_hold_disabled();
    mode_sel = 2'b01; b_en_hi = 1'b0; b_en_lo = 1'b1; oe_a = 1'b0;
    a_in = 9'h1A5; b_in = 9'h05A; pulse_ab(); pulse_ba();
    check("R8 disabled released", b_released, 9'h1FF);
    a_in = 9'h000; b_in = 9'h1FF; b_on(); oe_a = 1'b1; step();
    check("R8 enabled shows stored pull", b_pull_low, 9'h1A5);
    check("R8 stored aout", a_out, 9'h1A5);
    check("R8 a drives", {8'h0, a_drive}, 9'h001);
  endtask

  task automatic t_power();
    mode_sel = 2'b10; b_on(); a_in = 9'h0FF; step();
    check("R9 power good pull", b_pull_low, 9'h0FF);
    pwr_good = 1'b0; step();
    check("R9 power bad pull", b_pull_low, 9'h000);
    check("R9 power bad rel", b_released, 9'h1FF);
    pwr_good = 1'b1; step();
    check("R9 power back", b_pull_low, 9'h0FF);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    oe_a = 1'b1;
    t_reset();
    t_pass();
    t_reg();
    t_latch();
    t_split();
    t_enables();
    t_hold_disabled();
    t_power();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule